// File: doc/BRIEF.md
# Machine Trap Entry and Return Unit

This unit keeps the machine-level trap state of a 32-bit core: the saved return address, the recorded cause, the global interrupt enable with its saved copy, and the trap vector base with its dispatch mode. It also produces the program-counter redirect that the fetch stage follows. The pipeline raises a one-cycle trap strobe. The strobe carries the PC to save and an interrupt flag. For an interrupt it also carries the interrupt code. For an exception it carries a vector of individual request bits, and the unit reduces these to one cause by a fixed priority. A separate strobe requests the return from a handler. Software writes the vector, the return address and the status bits through a small write port.

A three-state machine holds what the unit is issuing in the current cycle. `ST_IDLE` issues nothing. `ST_TRAP` issues the handler address. `ST_RET` issues the saved return address. The TAKE transition, from any state, goes to `ST_TRAP` when a trap fires. The RETURN transition goes to `ST_RET` when a return strobe arrives with no trap. The QUIET transition goes to `ST_IDLE` otherwise. A redirect therefore appears one cycle after its strobe and lasts one cycle. Trap strobes and return strobes may arrive back to back.

Top module: `mtrap_unit`

## Requirements
- R1: After reset, the redirect valid output is 0, and the saved PC, the cause, the vector register, the enable bit and the saved-enable bit all read 0.
- R2: When a trap fires, the following hold one cycle later:
  - the saved PC equals `trap_pc_i`;
  - the saved-enable bit equals the enable bit from before the trap;
  - the enable bit is 0;
  - the cause reads the interrupt flag in bit 31, zeros in bits 30:8, and the 8-bit code in bits 7:0.
- R3: An exception redirects to the vector base in every mode.
- R4: An interrupt redirects to the vector base when the mode field is 0, 2 or 3.
- R5: When the mode field is 1, an interrupt redirects to base + 4 × code. This includes the codes 128 to 131, whose offset reaches past the 256-byte window.
- R6: A write to the vector register keeps data bits 31:8 as the base and bits 1:0 as the mode. Bits 7:2 read 0.
- R7: A return strobe redirects to the saved PC, copies the saved-enable bit into the enable bit, and sets the saved-enable bit to 1.
- R8: Exception request bits are ranked by index, and bit 0 wins. The codes by index 0 to 10 are 3, 1, 49, 48, 2, 8, 11, 3, 3, 7, 5. The winner's code is recorded.
- R9: A trap and a return strobe in the same cycle produce only the trap redirect and the trap state update.
- R10: The write select is 0 for the vector register, 1 for the saved PC and 2 for status. A status write takes the enable bit from data bit 3 and the saved-enable bit from data bit 7. A write in the same cycle as a trap or a return strobe is dropped.
- R11: A trap strobe with the interrupt flag clear and no exception request bit set is ignored. There is no redirect, and the state does not change.
- R12: Each fired trap or return produces exactly one redirect cycle, in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trap_valid_i | input | 1 | Trap request strobe |
| trap_pc_i | input | 32 | PC to save on trap entry |
| trap_is_irq_i | input | 1 | 1: interrupt, 0: exception |
| trap_irq_code_i | input | 8 | Interrupt code (used when trap_is_irq_i is 1) |
| exc_req_i | input | 11 | Exception request bits, index 0 has the highest priority |
| mret_i | input | 1 | Return-from-handler strobe |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 2 | CSR select: 0 vector, 1 saved PC, 2 status |
| csr_wdata_i | input | 32 | CSR write data |
| redirect_valid_o | output | 1 | Redirect issued this cycle |
| redirect_pc_o | output | 32 | Redirect target |
| mepc_o | output | 32 | Saved PC |
| mcause_o | output | 32 | Trap cause |
| mtvec_o | output | 32 | Vector base and mode |
| mie_o | output | 1 | Global interrupt enable |
| mpie_o | output | 1 | Saved interrupt enable |

## Verification
Each fault in the held state appears at the ports within one cycle:
- A corrupted enable or saved-enable bit shows on `mie_o` or `mpie_o` right after the trap or return edge that moves it.
- A wrong state in the machine shows as a missing, doubled or misdirected redirect pulse in the cycle after the strobe.
- A wrong priority ranking or offset arithmetic shows in the same redirect cycle through `mcause_o` and `redirect_pc_o`.

Sweeping every combination of exception requests and every interrupt code exposes any single wrong entry in the priority ranking or in the offset computation.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    localparam int unsigned EXC_N = 11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TRAP = 2'd1,
        ST_RET  = 2'd2
    } redir_state_e;

    typedef enum logic [1:0] {
        SEL_VEC    = 2'd0,
        SEL_EPC    = 2'd1,
        SEL_STATUS = 2'd2
    } csr_sel_e;

    localparam int unsigned EN_BIT      = 3;
    localparam int unsigned SAVED_EN_BIT = 7;
    localparam logic [1:0]  MODE_VECTOR = 2'd1;

    // Cause code for each exception request index; index 0 ranks highest.
    function automatic logic [7:0] exc_code_of(input int unsigned idx);
        logic [7:0] c;
        unique case (idx)
            0:       c = 8'd3;   // fetch address breakpoint
            1:       c = 8'd1;   // fetch access fault
            2:       c = 8'd49;  // fetch parity fault
            3:       c = 8'd48;  // fetch bus fault
            4:       c = 8'd2;   // illegal instruction
            5:       c = 8'd8;   // user environment call
            6:       c = 8'd11;  // machine environment call
            7:       c = 8'd3;   // environment break
            8:       c = 8'd3;   // data address breakpoint
            9:       c = 8'd7;   // store access fault
            default: c = 8'd5;   // load access fault
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mtrap_prio.sv
module mtrap_prio
    import mtrap_pkg::*;
#(
    parameter int unsigned N      = EXC_N,
    parameter int unsigned CODE_W = 8
) (
    input  logic [N-1:0]      req_i,
    output logic              any_o,
    output logic [N-1:0]      grant_o,
    output logic [CODE_W-1:0] code_o
);

    always_comb begin
        logic found;
        found   = 1'b0;
        grant_o = '0;
        for (int unsigned i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                grant_o[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    always_comb begin
        code_o = '0;
        for (int unsigned i = 0; i < N; i++) begin
            if (grant_o[i]) begin
                code_o = CODE_W'(exc_code_of(i));
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/mtrap_vec.sv
module mtrap_vec
    import mtrap_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned CODE_W = 8
) (
    input  logic [XLEN-1:0]   base_i,
    input  logic [1:0]        mode_i,
    input  logic              is_irq_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [XLEN-1:0]   target_o
);

    localparam int unsigned OFF_W = CODE_W + 2;

    logic [OFF_W-1:0] offset;
    logic             use_offset;

    assign offset     = {code_i, 2'b00};
    assign use_offset = is_irq_i && (mode_i == MODE_VECTOR);

    always_comb begin
        if (use_offset) begin
            target_o = base_i + XLEN'(offset);
        end else begin
            target_o = base_i;
        end
    end

endmodule

// File: rtl/mtrap_csr.sv
module mtrap_csr
    import mtrap_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CODE_W  = 8,
    parameter int unsigned ALIGN_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              trap_fire_i,
    input  logic [XLEN-1:0]   trap_pc_i,
    input  logic              trap_irq_i,
    input  logic [CODE_W-1:0] trap_code_i,
    input  logic              mret_fire_i,
    input  logic              csr_we_i,
    input  logic [1:0]        csr_sel_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   mepc_o,
    output logic [XLEN-1:0]   mcause_o,
    output logic [XLEN-1:0]   vec_base_o,
    output logic [1:0]        vec_mode_o,
    output logic              mie_o,
    output logic              mpie_o
);

    localparam int unsigned PAD_W = XLEN - 1 - CODE_W;

    logic [XLEN-1:ALIGN_W] base_q;
    logic [1:0]            mode_q;
    logic [XLEN-1:0]       epc_q;
    logic [XLEN-1:0]       cause_q;
    logic                  en_q;
    logic                  saved_en_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            base_q     <= '0;
            mode_q     <= '0;
            epc_q      <= '0;
            cause_q    <= '0;
            en_q       <= 1'b0;
            saved_en_q <= 1'b0;
        end else if (trap_fire_i) begin
            epc_q      <= trap_pc_i;
            cause_q    <= {trap_irq_i, {PAD_W{1'b0}}, trap_code_i};
            saved_en_q <= en_q;
            en_q       <= 1'b0;
        end else if (mret_fire_i) begin
            en_q       <= saved_en_q;
            saved_en_q <= 1'b1;
        end else if (csr_we_i) begin
            unique case (csr_sel_e'(csr_sel_i))
                SEL_VEC: begin
                    base_q <= csr_wdata_i[XLEN-1:ALIGN_W];
                    mode_q <= csr_wdata_i[1:0];
                end
                SEL_EPC: begin
                    epc_q <= csr_wdata_i;
                end
                SEL_STATUS: begin
                    en_q       <= csr_wdata_i[EN_BIT];
                    saved_en_q <= csr_wdata_i[SAVED_EN_BIT];
                end
                default: ;
            endcase
        end
    end

    assign mepc_o     = epc_q;
    assign mcause_o   = cause_q;
    assign vec_base_o = {base_q, {ALIGN_W{1'b0}}};
    assign vec_mode_o = mode_q;
    assign mie_o      = en_q;
    assign mpie_o     = saved_en_q;

    assert_trap_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_fire_i |=> (!en_q && saved_en_q == $past(en_q) && epc_q == $past(trap_pc_i)));

    assert_return_restore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mret_fire_i |=> (saved_en_q && en_q == $past(saved_en_q)));

    assert_write_dropped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && mret_fire_i) |=> ($stable(base_q) && $stable(mode_q) && $stable(epc_q)));

endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
    import mtrap_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CODE_W  = 8,
    parameter int unsigned ALIGN_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              trap_valid_i,
    input  logic [XLEN-1:0]   trap_pc_i,
    input  logic              trap_is_irq_i,
    input  logic [CODE_W-1:0] trap_irq_code_i,
    input  logic [EXC_N-1:0]  exc_req_i,
    input  logic              mret_i,
    input  logic              csr_we_i,
    input  logic [1:0]        csr_sel_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic              redirect_valid_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [XLEN-1:0]   mepc_o,
    output logic [XLEN-1:0]   mcause_o,
    output logic [XLEN-1:0]   mtvec_o,
    output logic              mie_o,
    output logic              mpie_o
);

    logic              exc_any;
    logic [EXC_N-1:0]  exc_grant;
    logic [CODE_W-1:0] exc_code;
    logic              trap_fire;
    logic              mret_fire;
    logic [CODE_W-1:0] cause_code;
    logic [XLEN-1:0]   vec_base;
    logic [1:0]        vec_mode;
    logic [XLEN-1:0]   trap_target;

    redir_state_e    state_q, state_d;
    logic [XLEN-1:0] target_q, target_d;

    mtrap_prio #(.N(EXC_N), .CODE_W(CODE_W)) prio_i (
        .req_i   (exc_req_i),
        .any_o   (exc_any),
        .grant_o (exc_grant),
        .code_o  (exc_code)
    );

    assign trap_fire  = trap_valid_i && (trap_is_irq_i || exc_any);
    assign mret_fire  = mret_i && !trap_fire;
    assign cause_code = trap_is_irq_i ? trap_irq_code_i : exc_code;

    mtrap_csr #(.XLEN(XLEN), .CODE_W(CODE_W), .ALIGN_W(ALIGN_W)) csr_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .trap_fire_i (trap_fire),
        .trap_pc_i   (trap_pc_i),
        .trap_irq_i  (trap_is_irq_i),
        .trap_code_i (cause_code),
        .mret_fire_i (mret_fire),
        .csr_we_i    (csr_we_i),
        .csr_sel_i   (csr_sel_i),
        .csr_wdata_i (csr_wdata_i),
        .mepc_o      (mepc_o),
        .mcause_o    (mcause_o),
        .vec_base_o  (vec_base),
        .vec_mode_o  (vec_mode),
        .mie_o       (mie_o),
        .mpie_o      (mpie_o)
    );

    mtrap_vec #(.XLEN(XLEN), .CODE_W(CODE_W)) vec_i (
        .base_i   (vec_base),
        .mode_i   (vec_mode),
        .is_irq_i (trap_is_irq_i),
        .code_i   (cause_code),
        .target_o (trap_target)
    );

    assign mtvec_o = {vec_base[XLEN-1:2], vec_mode};

    // Next-state logic: TAKE, RETURN, QUIET.
    always_comb begin
        state_d  = ST_IDLE;
        target_d = target_q;
        if (trap_fire) begin
            state_d  = ST_TRAP;
            target_d = trap_target;
        end else if (mret_i) begin
            state_d  = ST_RET;
            target_d = mepc_o;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q  <= ST_IDLE;
            target_q <= '0;
        end else begin
            state_q  <= state_d;
            target_q <= target_d;
        end
    end

    always_comb begin
        redirect_valid_o = 1'b0;
        redirect_pc_o    = target_q;
        unique case (state_q)
            ST_IDLE: redirect_valid_o = 1'b0;
            ST_TRAP: redirect_valid_o = 1'b1;
            ST_RET:  redirect_valid_o = 1'b1;
            default: redirect_valid_o = 1'b0;
        endcase
    end

    assert_grant_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_any |-> $onehot(exc_grant));

    assert_exc_to_base_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_TRAP && !mcause_o[XLEN-1]) |-> (redirect_pc_o == vec_base));

    assert_return_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RET) |-> (redirect_pc_o == mepc_o));

    assert_pulse_origin_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_fire || mret_i) |=> redirect_valid_o);

    assert_trap_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_fire && mret_i) |=> (state_q == ST_TRAP && !mie_o));

    assert_idle_when_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!trap_fire && !mret_i) |=> !redirect_valid_o);

endmodule

// File: tb/mtrap_unit_tb_top.sv
`timescale 1ns/1ps
module mtrap_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 1'b0;
    logic [31:0] trap_pc = '0;
    logic        trap_irq = 1'b0;
    logic [7:0]  irq_code = '0;
    logic [10:0] exc_req = '0;
    logic        mret = 1'b0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic        rvalid;
    logic [31:0] rpc, mepc, mcause, mtvec;
    logic        mie, mpie;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [31:0] m_base = '0;
    logic [1:0]  m_mode = '0;
    logic [31:0] m_epc = '0;
    logic        m_en = 1'b0;
    logic        m_sav = 1'b0;

    always #10 clk = ~clk;

    mtrap_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(trap_valid), .trap_pc_i(trap_pc),
        .trap_is_irq_i(trap_irq), .trap_irq_code_i(irq_code), .exc_req_i(exc_req),
        .mret_i(mret), .csr_we_i(csr_we), .csr_sel_i(csr_sel), .csr_wdata_i(csr_wdata),
        .redirect_valid_o(rvalid), .redirect_pc_o(rpc), .mepc_o(mepc), .mcause_o(mcause),
        .mtvec_o(mtvec), .mie_o(mie), .mpie_o(mpie)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_code(input logic [10:0] r);
        for (int i = 0; i < 11; i++) begin
            if (r[i]) begin
                case (i)
                    0: return 8'd3;   1: return 8'd1;   2: return 8'd49;
                    3: return 8'd48;  4: return 8'd2;   5: return 8'd8;
                    6: return 8'd11;  7: return 8'd3;   8: return 8'd3;
                    9: return 8'd7;   default: return 8'd5;
                endcase
            end
        end
        return 8'd0;
    endfunction

    task automatic clear_inputs();
        trap_valid = 0; trap_irq = 0; irq_code = 0; exc_req = 0;
        mret = 0; csr_we = 0; csr_sel = 0; csr_wdata = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1; csr_sel = sel; csr_wdata = d;
        @(negedge clk);
        clear_inputs();
        case (sel)
            2'd0: begin m_base = {d[31:8], 8'h00}; m_mode = d[1:0]; end
            2'd1: m_epc = d;
            2'd2: begin m_en = d[3]; m_sav = d[7]; end
            default: ;
        endcase
    endtask

    // Drive one strobe cycle; outputs are sampled on the following negedge.
    task automatic strobe(input logic tv, input logic [31:0] pc, input logic irq,
                          input logic [7:0] code, input logic [10:0] ex, input logic mr,
                          input logic we, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        trap_valid = tv; trap_pc = pc; trap_irq = irq; irq_code = code; exc_req = ex;
        mret = mr; csr_we = we; csr_sel = sel; csr_wdata = d;
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic check_pulse_end(input string tag);
        @(negedge clk);
        chk(tag, {31'd0, rvalid}, 32'd0);
    endtask

    initial begin
        clear_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1 valid", {31'd0, rvalid}, 32'd0);
        chk("R1 mepc", mepc, 32'd0);
        chk("R1 mcause", mcause, 32'd0);
        chk("R1 mtvec", mtvec, 32'd0);
        chk("R1 mie/mpie", {30'd0, mie, mpie}, 32'd0);

        // R6 vector write masks bits 7:2
        wr(2'd0, 32'h1234_56FF);
        chk("R6 mtvec", mtvec, 32'h1234_5603);
        // R10 status write bit positions
        wr(2'd2, 32'h0000_0088);
        chk("R10 status", {30'd0, mie, mpie}, 32'd3);
        wr(2'd2, 32'h0000_0008);
        chk("R10 status en only", {30'd0, mie, mpie}, 32'd2);
        wr(2'd1, 32'hCAFE_0000);
        chk("R10 epc write", mepc, 32'hCAFE_0000);

        // R5 vectored interrupt sweep over all codes, plus R2 entry state
        wr(2'd0, 32'h8000_0101);
        chk("R6 mtvec vectored", mtvec, 32'h8000_0101);
        for (int c = 0; c < 256; c++) begin
            logic [31:0] pc;
            logic        old_en;
            pc = 32'h4000_0000 + 32'(c) * 4;
            wr(2'd2, {24'd0, c[1], 3'd0, c[0], 3'd0});
            old_en = m_en;
            strobe(1, pc, 1, 8'(c), 11'd0, 0, 0, 2'd0, 32'd0);
            chk("R12 trap valid", {31'd0, rvalid}, 32'd1);
            chk("R5 vectored target", rpc, m_base + 32'(c) * 4);
            chk("R2 mepc", mepc, pc);
            chk("R2 mcause", mcause, {1'b1, 23'd0, 8'(c)});
            chk("R2 en/saved", {30'd0, mie, mpie}, {30'd0, 1'b0, old_en});
            m_en = 0; m_sav = old_en; m_epc = pc;
            check_pulse_end("R12 pulse end");
        end

        // R4 direct-like modes: 0, 2, 3
        for (int md = 0; md < 4; md++) begin
            if (md != 1) begin
                wr(2'd0, {24'h00C0_00, 6'd0, 2'(md)});
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] cd;
                    cd = (k == 0) ? 8'd7 : (k == 1) ? 8'd16 : (k == 2) ? 8'd31 : 8'd131;
                    strobe(1, 32'h100, 1, cd, 11'd0, 0, 0, 2'd0, 32'd0);
                    chk("R4 direct target", rpc, m_base);
                    chk("R4 mcause", mcause, {1'b1, 23'd0, cd});
                end
            end
        end

        // R3/R8 every exception combination, vectored mode
        wr(2'd0, 32'h9000_0201);
        for (int e = 1; e < 2048; e++) begin
            strobe(1, 32'(e) << 2, 0, 8'hFF, 11'(e), 0, 0, 2'd0, 32'd0);
            chk("R3 exc target", rpc, m_base);
            chk("R8 exc cause", mcause, {24'd0, ref_code(11'(e))});
            if (rvalid !== 1'b1) chk("R12 exc valid", {31'd0, rvalid}, 32'd1);
        end
        m_epc = 32'(2047) << 2;
        m_en = 0; m_sav = 0;

        // R11 ignored request: no irq, no exception bits
        strobe(1, 32'hDEAD_BEE0, 0, 8'd9, 11'd0, 0, 0, 2'd0, 32'd0);
        chk("R11 no redirect", {31'd0, rvalid}, 32'd0);
        chk("R11 mepc unchanged", mepc, m_epc);
        chk("R11 mcause unchanged", mcause, {24'd0, ref_code(11'd2047)});

        // R7 return with saved-enable 1 and 0
        wr(2'd1, 32'h0000_5550);
        wr(2'd2, 32'h0000_0080);
        strobe(0, 0, 0, 0, 0, 1, 0, 2'd0, 32'd0);
        chk("R7 ret valid", {31'd0, rvalid}, 32'd1);
        chk("R7 ret target", rpc, 32'h0000_5550);
        chk("R7 en/saved after", {30'd0, mie, mpie}, 32'd3);
        check_pulse_end("R12 ret pulse end");
        wr(2'd2, 32'h0000_0008);
        strobe(0, 0, 0, 0, 0, 1, 0, 2'd0, 32'd0);
        chk("R7 en from saved 0", {30'd0, mie, mpie}, 32'd1);

        // R9 trap and return together
        wr(2'd2, 32'h0000_0008);
        strobe(1, 32'h0000_7770, 1, 8'd11, 11'd0, 1, 0, 2'd0, 32'd0);
        chk("R9 valid", {31'd0, rvalid}, 32'd1);
        chk("R9 target", rpc, m_base + 32'd44);
        chk("R9 mepc", mepc, 32'h0000_7770);
        chk("R9 en/saved", {30'd0, mie, mpie}, 32'd1);
        check_pulse_end("R9 single pulse");

        // R10 write dropped alongside trap and return
        strobe(1, 32'h0000_AAA0, 0, 0, 11'b100_0000_0000, 0, 1, 2'd1, 32'h1111_1110);
        chk("R10 epc write dropped by trap", mepc, 32'h0000_AAA0);
        strobe(0, 0, 0, 0, 0, 1, 1, 2'd0, 32'hFFFF_FF00);
        chk("R10 vec write dropped by return", mtvec, 32'h9000_0201);
        chk("R7 return to trap pc", rpc, 32'h0000_AAA0);

        // R12 back-to-back trap then return
        @(negedge clk);
        trap_valid = 1; trap_pc = 32'h0000_0C00; trap_irq = 1; irq_code = 8'd3;
        @(negedge clk);
        clear_inputs(); mret = 1;
        chk("R12 b2b trap", rpc, m_base + 32'd12);
        @(negedge clk);
        clear_inputs();
        chk("R12 b2b ret valid", {31'd0, rvalid}, 32'd1);
        chk("R12 b2b ret target", rpc, 32'h0000_0C00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule